// File: doc/BRIEF.md
# CIC Decimator with Coarse Power-of-Two Gain

This block lowers the sample rate of one complex baseband channel. Signed I and Q samples arrive with a valid strobe. Each lane passes through four cascaded integrators that run at the input rate. Every R accepted samples, one value moves through four comb (differencing) stages with a differential delay of one. The result is scaled down so that the DC gain never exceeds unity. A coarse gain stage then shifts it left by 0 to 7 bits, which is 0 to 42 dB in 6 dB steps. The shift saturates at the output code limits.

The ratio R and the gain code are plain input ports that are sampled continuously. Both lanes always use the same settings. When the ratio port changes, the decimation phase restarts and the comb history is cleared. The integrators keep their state, and because they wrap in two's complement, no integrator flush is needed. The first few outputs after a ratio change carry the transient of the cleared combs. They are valid again from the fifth output onward.

Top module: `cic_decim_gain`

## Requirements
- R1: For a constant input x held long enough, each settled output equals sat(round(x·R^4 / 2^S) · 2^g). This holds separately on I and Q. The integrators are IN_W+56 bits wide and wrap modulo that width.
- R2: `out_valid` pulses once for every R accepted inputs. It is never high on two consecutive cycles. It rises two clock cycles after the input that completes the group is accepted.
- R3: Ratio port values below 8 act as 8. Values above 16384 act as 16384. Values in between are used as they are.
- R4: The scaling shift is S = 4·ceil(log2 R). Rounding adds half an LSB of the shifted result and then takes the floor, so an exact half rounds toward +infinity. For example, x = -5 at R = 10 gives -1.
- R5: Gain code g (3 bits, 0..7) shifts the scaled value left by g bits, a gain of 6·g dB.
- R6: A shifted value above 2^(OUT_W-1)-1 gives 32767, and one below -2^(OUT_W-1) gives -32768 (16-bit output). The sign of the scaled value is always kept.
- R7: The I and Q lanes are filtered independently, with the same ratio and gain.
- R8: A ratio port value that differs from the held value clears the decimation counter and all comb delays. The first output after the change follows exactly R accepted inputs.
- R9: Reset forces `out_valid`, `out_i` and `out_q` to zero and clears the integrators. Reset is asynchronous and is released synchronously.
- R10: A cycle with `in_valid` low neither integrates nor counts its data. With `in_valid` held low, no output is produced and the held outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | IN_W | Signed in-phase sample |
| in_q | input | IN_W | Signed quadrature sample |
| ratio | input | RATIO_W | Decimation ratio R, clamped to 8..16384 |
| gain | input | GAIN_W | Coarse gain code, left shift of 0..7 bits |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | OUT_W | Signed decimated in-phase sample |
| out_q | output | OUT_W | Signed decimated quadrature sample |

## Verification
The bench builds the block with its defaults: 16-bit input and output, a 15-bit ratio port and a 3-bit gain code. With a 15-bit port, ratios above 16384 can be driven, so the upper clamp is reachable. A full run at R = 16384 drives the 72-bit integrators well past wraparound, which tests the modular arithmetic. The 16-bit output limits make the saturation corners easy to reach with full-scale input and the top gain code.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Number of integrator stages and of comb stages
  localparam int unsigned CIC_STAGES = 4;
  // Parallel lanes: 0 = in-phase, 1 = quadrature
  localparam int unsigned CIC_LANES  = 2;

  // Smallest n with 2**n >= v, for v >= 1
  function automatic int unsigned ceil_log2(input int unsigned v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (((v - 1) >> i) != 0) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int unsigned W = 72,
  parameter int unsigned N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] acc_q [N];
  logic signed [W-1:0] acc_d [N];

  // Pipelined cascade: each stage adds the previous stage's registered sum.
  // Sums wrap modulo 2**W; the comb section recovers the true value.
  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign acc_d[k] = acc_q[k] + din;
    end else begin : g_body
      assign acc_d[k] = acc_q[k] + acc_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) acc_q[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < N; k++) acc_q[k] <= acc_d[k];
    end
  end

  assign dout = acc_q[N-1];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int unsigned W = 72,
  parameter int unsigned N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] dly_q [N];
  logic signed [W-1:0] stg   [N+1];

  assign stg[0] = din;

  // Differential delay of one decimated sample per stage
  for (genvar k = 0; k < N; k++) begin : g_diff
    assign stg[k+1] = stg[k] - dly_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) dly_q[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < N; k++) dly_q[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < N; k++) dly_q[k] <= stg[k];
    end
  end

  assign dout = stg[N];
endmodule

// File: rtl/cic_scale_sat.sv
module cic_scale_sat #(
  parameter int unsigned ACC_W = 72,
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SH_W  = 6,
  parameter int unsigned G_W   = 3
) (
  input  logic signed [ACC_W-1:0] cic,
  input  logic        [SH_W-1:0]  shift,
  input  logic        [G_W-1:0]   gain,
  output logic signed [OUT_W-1:0] y
);
  localparam int unsigned SC_W  = IN_W + 1;
  localparam int unsigned EXT_W = SC_W + (2**G_W - 1);
  localparam logic signed [EXT_W-1:0] OMAX =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] OMIN =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W:0]   half;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W:0]   shr;
  logic signed [SC_W-1:0]  scaled;
  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] shl;

  always_comb begin
    // Round half toward +inf, then drop the growth bits
    half   = (shift != '0) ? ((ACC_W+1)'(1) << (shift - 1'b1)) : '0;
    sum    = {cic[ACC_W-1], cic} + half;
    shr    = sum >>> shift;
    scaled = shr[SC_W-1:0];
    ext    = {{(EXT_W-SC_W){scaled[SC_W-1]}}, scaled};
    shl    = ext <<< gain;
    if (shl > OMAX)      y = OMAX[OUT_W-1:0];
    else if (shl < OMIN) y = OMIN[OUT_W-1:0];
    else                 y = shl[OUT_W-1:0];
  end

  // R6: gain and clipping never flip the sign of the scaled sample
  always_comb begin
    p_sign_kept_r6: assert ((scaled < 0) == (y < 0))
      else $error("gain stage changed sign");
  end
endmodule

// File: rtl/cic_decim_gain.sv
module cic_decim_gain #(
  parameter int unsigned IN_W      = 16,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned GAIN_W    = 3,
  parameter int unsigned RATIO_MIN = 8,
  parameter int unsigned RATIO_MAX = 16384
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [IN_W-1:0]    in_i,
  input  logic signed [IN_W-1:0]    in_q,
  input  logic        [RATIO_W-1:0] ratio,
  input  logic        [GAIN_W-1:0]  gain,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_i,
  output logic signed [OUT_W-1:0]   out_q
);
  localparam int unsigned N        = cic_pkg::CIC_STAGES;
  localparam int unsigned LANES    = cic_pkg::CIC_LANES;
  localparam int unsigned LOG_RMAX = cic_pkg::ceil_log2(RATIO_MAX);
  localparam int unsigned ACC_W    = IN_W + N * LOG_RMAX;
  localparam int unsigned SH_W     = $clog2(N * LOG_RMAX + 1);
  localparam logic [SH_W-1:0] SH_RST = SH_W'(N * cic_pkg::ceil_log2(RATIO_MIN));

  logic rst_s_n;

  cic_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // ---------------- configuration and decimation phase ----------------
  logic [RATIO_W-1:0] ratio_q, ratio_eff_q, r_clamp;
  logic [SH_W-1:0]    shift_q, shift_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               cfg_chg, dec_hit;
  logic               cic_v_q, out_v_q;

  always_comb begin
    r_clamp = ratio;
    if (ratio < RATIO_W'(RATIO_MIN))      r_clamp = RATIO_W'(RATIO_MIN);
    else if (ratio > RATIO_W'(RATIO_MAX)) r_clamp = RATIO_W'(RATIO_MAX);
    shift_d = SH_W'(N * cic_pkg::ceil_log2(32'(r_clamp)));
    cfg_chg = (ratio != ratio_q);
    dec_hit = in_valid && !cfg_chg && (cnt_q == ratio_eff_q - 1'b1);
    cnt_d   = cnt_q;
    if (cfg_chg)       cnt_d = '0;
    else if (dec_hit)  cnt_d = '0;
    else if (in_valid) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ratio_q     <= '0;
      ratio_eff_q <= RATIO_W'(RATIO_MIN);
      shift_q     <= SH_RST;
    end else if (cfg_chg) begin
      ratio_q     <= ratio;
      ratio_eff_q <= r_clamp;
      shift_q     <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q   <= '0;
      cic_v_q <= 1'b0;
      out_v_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cic_v_q <= dec_hit;
      out_v_q <= cic_v_q;
    end
  end

  assign out_valid = out_v_q;

  // ---------------- per-lane datapath ----------------
  logic signed [IN_W-1:0]  lane_in  [LANES];
  logic signed [OUT_W-1:0] lane_out [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACC_W-1:0] integ_in, integ_out, comb_out;
    logic signed [ACC_W-1:0] cic_r;
    logic signed [OUT_W-1:0] gain_y, out_r;

    assign integ_in = {{(ACC_W-IN_W){lane_in[l][IN_W-1]}}, lane_in[l]};

    cic_integ_chain #(.W(ACC_W), .N(N)) u_integ (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (in_valid),
      .din   (integ_in),
      .dout  (integ_out)
    );

    cic_comb_chain #(.W(ACC_W), .N(N)) u_comb (
      .clk   (clk),
      .rst_n (rst_s_n),
      .clr   (cfg_chg),
      .en    (dec_hit),
      .din   (integ_out),
      .dout  (comb_out)
    );

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)     cic_r <= '0;
      else if (dec_hit) cic_r <= comb_out;
    end

    cic_scale_sat #(
      .ACC_W (ACC_W), .IN_W (IN_W), .OUT_W (OUT_W),
      .SH_W  (SH_W),  .G_W  (GAIN_W)
    ) u_scale (
      .cic   (cic_r),
      .shift (shift_q),
      .gain  (gain),
      .y     (gain_y)
    );

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)     out_r <= '0;
      else if (cic_v_q) out_r <= gain_y;
    end

    assign lane_out[l] = out_r;
  end

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];

  // ---------------- assertions ----------------
  // R2: at most one output strobe per cycle pair
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |=> !out_valid);

  // R2: the phase counter stays inside the active ratio
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_q < ratio_eff_q);

  // R3: the ratio in use always lies in the legal window
  p_ratio_window_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ratio_eff_q >= RATIO_W'(RATIO_MIN)) && (ratio_eff_q <= RATIO_W'(RATIO_MAX)));

  // R8: a ratio change never emits a decimated sample
  p_no_emit_on_change_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_chg |=> !cic_v_q);

  // R10: every output strobe stems from an accepted input two cycles back
  p_out_from_input_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/cic_decim_gain_tb.sv
`timescale 1ns/1ps
module cic_decim_gain_tb;

  typedef struct packed {
    logic        [14:0] ratio;
    logic        [2:0]  gain;
    logic signed [15:0] xi;
    logic signed [15:0] xq;
    logic               gap;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{15'd8,     3'd0, 16'sd1000,   -16'sd1000,  1'b0},
    '{15'd10,    3'd0, 16'sd16000,  -16'sd5,     1'b0},
    '{15'd16,    3'd3, 16'sd300,    -16'sd300,   1'b0},
    '{15'd100,   3'd7, 16'sd32767,  16'sh8000,   1'b0},
    '{15'd4,     3'd1, 16'sd50,     16'sd7,      1'b0},
    '{15'd33,    3'd0, 16'sd10000,  -16'sd10000, 1'b0},
    '{15'd8,     3'd2, -16'sd77,    16'sd77,     1'b1},
    '{15'd20000, 3'd0, -16'sd12345, 16'sd222,    1'b0}
  };

  logic               clk, rst_n, in_valid, out_valid;
  logic signed [15:0] in_i, in_q, out_i, out_q;
  logic [14:0]        ratio;
  logic [2:0]         gain;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  cic_decim_gain u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .ratio     (ratio),
    .gain      (gain),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_ratio(input int r);
    if (r < 8)     return 8;
    if (r > 16384) return 16384;
    return r;
  endfunction

  // Settled DC response from the requirement formula (R1, R4, R5, R6)
  function automatic longint expect_out(input int r, input int g, input int x);
    int rc, c, s;
    logic signed [95:0] full, rw, rnd, v;
    rc = clamp_ratio(r);
    c  = 0;
    while ((1 << c) < rc) c++;
    s    = 4 * c;
    full = 96'(x);
    rw   = 96'(rc);
    for (int k = 0; k < 4; k++) full = full * rw;
    rnd = (full + (96'sd1 <<< (s - 1))) >>> s;
    v   = rnd <<< g;
    if (v > 96'sd32767)  return 32767;
    if (v < -96'sd32768) return -32768;
    return longint'(v);
  endfunction

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1/R7";
      1: return "R1/R4";
      2: return "R1/R5";
      3: return "R1/R6";
      4: return "R1/R3";
      5: return "R1/R4/R7";
      6: return "R1/R10";
      default: return "R1/R3";
    endcase
  endfunction

  task automatic run_vec(input int idx);
    vec_t   v;
    int     rc, nout, acc, at, prev_at;
    bit     drove, phase;
    longint ei, eq;
    v  = VEC[idx];
    rc = clamp_ratio(int'(v.ratio));
    ei = expect_out(int'(v.ratio), int'(v.gain), int'(v.xi));
    eq = expect_out(int'(v.ratio), int'(v.gain), int'(v.xq));
    in_valid = 1'b0;
    ratio    = v.ratio;
    gain     = v.gain;
    repeat (3) @(negedge clk);
    nout = 0; acc = 0; at = 0; prev_at = 0; drove = 1'b0; phase = 1'b0;
    while (nout < 6) begin
      if (out_valid) begin
        nout++;
        at = acc;
        if (nout == 1)
          chk(at == rc, "R8", $sformatf("vec%0d inputs to first output", idx), at, rc);
        if (nout == 6) begin
          chk(at - prev_at == rc, "R2", $sformatf("vec%0d inputs per output", idx),
              at - prev_at, rc);
          chk(out_i == ei, vec_tag(idx), $sformatf("vec%0d out_i", idx), out_i, ei);
          chk(out_q == eq, vec_tag(idx), $sformatf("vec%0d out_q", idx), out_q, eq);
        end
        prev_at = at;
      end
      if (drove) acc++;
      if (v.gap && phase) begin
        in_valid = 1'b0;
        in_i     = 16'sd12345;
        in_q     = -16'sd999;
        drove    = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_i     = v.xi;
        in_q     = v.xq;
        drove    = 1'b1;
      end
      phase = ~phase;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int             seen;
    logic signed [15:0] hold_i, hold_q;
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    ratio = 15'd8; gain = 3'd0;
    repeat (5) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    chk(out_i == 16'sd0,   "R9", "out_i in reset", out_i, 0);
    chk(out_q == 16'sd0,   "R9", "out_q in reset", out_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // R10: idle inputs with changing data produce nothing and disturb nothing
    hold_i = out_i; hold_q = out_q; seen = 0;
    for (int k = 0; k < 100; k++) begin
      in_valid = 1'b0;
      in_i = 16'(k * 321);
      in_q = 16'(-k * 77);
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R10", "strobes while idle", seen, 0);
    chk(out_i == hold_i && out_q == hold_q, "R10", "held out_i while idle", out_i, hold_i);

    // R9: asynchronous reset clears the held outputs at once
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_i == 16'sd0,   "R9", "out_i after reset", out_i, 0);
    chk(out_q == 16'sd0,   "R9", "out_q after reset", out_q, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule